// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is a trace sink. It writes incoming 32-bit trace words into an internal RAM that it addresses as a ring. Capture runs while software has it enabled. It ends on its own in two cases: when a programmed number of words has been stored after a trigger, or when a manual flush completes with stop-on-flush selected.

Software uses a small register port to program the block and to drain the RAM afterwards. The port has an address, a write strobe, write data, a read strobe and registered read data. Software can move the read and write pointers directly. The read-data and write-data windows step those pointers on every access, which lets software clear the RAM or unload it word by word. Trace data is treated as opaque 4-word frames. A flush therefore fills the current frame with zero words before it reports completion.

Register offsets: 0x004 depth (read-only), 0x00C status (bit 0 full), 0x010 read-data window, 0x014 read pointer, 0x018 write pointer, 0x01C post-trigger count, 0x020 control (bit 0 capture enable), 0x024 write-data window, 0x300 formatter status (bit 0 flush busy, bit 1 stopped), 0x304 formatter control (bit 0 formatting enable, bit 6 flush request/busy, bit 12 stop when flush done, bit 13 stop on trigger).

Top module: `trace_ring_sink`

## Requirements
- R1: After reset, trace input is not ready, both pointers read 0, status reads 0 and formatter status bit 1 (stopped) reads 1.
- R2: The depth register at 0x004 returns 2**ADDR_W, and its bit 31 is 0.
- R3: A write to 0x024 stores the word at the write pointer and advances the pointer by one. A read of 0x010 returns the word at the read pointer and advances that pointer by one. Both pointers wrap modulo the depth.
- R4: Status bit 0 (full) is set when the write pointer wraps from depth-1 to 0, and it stays set. A write to the write pointer clears it only while capture is disabled.
- R5: Trace input is ready only when all of these hold: capture is enabled, the block is not stopped, no flush is in progress, and no register write occurs in the same cycle. Each accepted word is stored at the write pointer, in arrival order.
- R6: Writes to the read and write pointers keep only the low ADDR_W bits and read back that way.
- R7: With control bit 13 set, a trigger pulse lets exactly the post-trigger count of further words be stored (a count of 0 stores none). The block then stops and the count reads 0. A trigger while bit 13 is clear has no effect.
- R8: A flush, started by the flush pin or by writing 1 to control bit 6, makes bit 6 read 1 while it runs. The flush stores zero words until the write pointer is a multiple of 4, then clears bit 6.
- R9: If formatter control bit 12 is set when a flush completes, formatter status bit 1 becomes 1 and trace input goes not-ready. If bit 12 is clear, capture continues.
- R10: Writing 0 to control disables capture and sets the stopped bit. Writing 1 re-arms capture and clears the stopped and triggered state.
- R11: Read data appears on the cycle after the read strobe. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 12 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Register read data, one cycle after strobe |
| trc_valid | input | 1 | Trace word valid |
| trc_data | input | 32 | Trace word |
| trc_ready | output | 1 | Trace word accepted when high with valid |
| trig_in | input | 1 | Single-cycle trigger |
| flush_in | input | 1 | Single-cycle flush request |

## Verification
The hardest state to reach from the ports is a flush that starts in the middle of a frame, with capture still live, while a register read is observing the busy bit. The bench streams a word count that is not a multiple of 4 and then pulses the flush pin. It reads formatter control while the padding is still in progress, and afterwards rewinds the read pointer to check that the padded slots hold zero. The post-trigger stop is swept with a zero count and with a nonzero count, and the bench counts accepted words cycle by cycle against the programmed value.

// File: rtl/trace_ring_sink.sv
module trace_ring_sink #(
  parameter int ADDR_W = 5,
  parameter int RA_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  input  logic             reg_rd,
  output logic [31:0]      reg_rdata,
  input  logic             trc_valid,
  input  logic [31:0]      trc_data,
  output logic             trc_ready,
  input  logic             trig_in,
  input  logic             flush_in
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [RA_W-1:0] O_DEPTH = RA_W'('h004);
  localparam logic [RA_W-1:0] O_STAT  = RA_W'('h00C);
  localparam logic [RA_W-1:0] O_RWIN  = RA_W'('h010);
  localparam logic [RA_W-1:0] O_RPTR  = RA_W'('h014);
  localparam logic [RA_W-1:0] O_WPTR  = RA_W'('h018);
  localparam logic [RA_W-1:0] O_TCNT  = RA_W'('h01C);
  localparam logic [RA_W-1:0] O_CTRL  = RA_W'('h020);
  localparam logic [RA_W-1:0] O_WWIN  = RA_W'('h024);
  localparam logic [RA_W-1:0] O_FSTAT = RA_W'('h300);
  localparam logic [RA_W-1:0] O_FCTRL = RA_W'('h304);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [31:0]       mem [DEPTH];
  logic [ADDR_W-1:0] wptr, rptr;
  logic [31:0]       tcnt;
  logic              full, cap_en, stopped, triggered, flushing;
  logic              fmt_en, stop_fl, stop_trg;

  wire wr_wwin  = reg_wr && reg_addr == O_WWIN;
  wire wr_wptr  = reg_wr && reg_addr == O_WPTR;
  wire wr_rptr  = reg_wr && reg_addr == O_RPTR;
  wire wr_tcnt  = reg_wr && reg_addr == O_TCNT;
  wire wr_ctrl  = reg_wr && reg_addr == O_CTRL;
  wire wr_fctrl = reg_wr && reg_addr == O_FCTRL;
  wire rd_rwin  = reg_rd && reg_addr == O_RWIN;

  wire live       = cap_en && !stopped;
  wire cnt_done   = triggered && tcnt == 32'd0;
  assign trc_ready = live && !flushing && !reg_wr && !cnt_done;
  wire accept     = trc_valid && trc_ready;
  wire pad        = flushing && live && !reg_wr && wptr[1:0] != 2'd0;
  wire flush_done = flushing && !reg_wr && (!live || wptr[1:0] == 2'd0);
  wire ram_we     = wr_wwin || accept || pad;
  wire [31:0] ram_wd = wr_wwin ? reg_wdata : (accept ? trc_data : 32'd0);
  wire flush_req  = flush_in || (wr_fctrl && reg_wdata[6]);

  always_ff @(posedge clk)
    if (ram_we) mem[wptr] <= ram_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; tcnt <= '0;
      full <= 1'b0; cap_en <= 1'b0; stopped <= 1'b1; triggered <= 1'b0;
      flushing <= 1'b0; fmt_en <= 1'b0; stop_fl <= 1'b0; stop_trg <= 1'b0;
    end else begin
      if (ram_we) begin
        wptr <= wptr + 1'b1;
        if (wptr == LAST) full <= 1'b1;
      end
      if (wr_wptr) begin
        wptr <= reg_wdata[ADDR_W-1:0];
        if (!cap_en) full <= 1'b0;
      end
      if (rd_rwin) rptr <= rptr + 1'b1;
      if (wr_rptr) rptr <= reg_wdata[ADDR_W-1:0];
      if (wr_tcnt) tcnt <= reg_wdata;
      else if (triggered && accept) tcnt <= tcnt - 1'b1;
      if (trig_in && stop_trg && live) triggered <= 1'b1;
      if (cnt_done) stopped <= 1'b1;
      if (flush_done) begin
        flushing <= 1'b0;
        if (stop_fl) stopped <= 1'b1;
      end else if (!flushing && flush_req) begin
        flushing <= 1'b1;
      end
      if (wr_fctrl) begin
        fmt_en   <= reg_wdata[0];
        stop_fl  <= reg_wdata[12];
        stop_trg <= reg_wdata[13];
      end
      if (wr_ctrl) begin
        cap_en    <= reg_wdata[0];
        stopped   <= !reg_wdata[0];
        triggered <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        O_DEPTH: reg_rdata <= 32'(DEPTH);
        O_STAT:  reg_rdata <= {31'd0, full};
        O_RWIN:  reg_rdata <= mem[rptr];
        O_RPTR:  reg_rdata <= 32'(rptr);
        O_WPTR:  reg_rdata <= 32'(wptr);
        O_TCNT:  reg_rdata <= tcnt;
        O_CTRL:  reg_rdata <= {31'd0, cap_en};
        O_FSTAT: reg_rdata <= {30'd0, stopped, flushing};
        O_FCTRL: reg_rdata <= {18'd0, stop_trg, stop_fl, 5'd0, flushing, 5'd0, fmt_en};
        default: reg_rdata <= '0;
      endcase
    end
  end

  a_r5_accept_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (trc_valid && trc_ready) |=> wptr == $past(wptr) + 1'b1);
  a_r4_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !wr_wptr) |=> full);
  a_r3_read_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rwin && !wr_rptr) |=> rptr == $past(rptr) + 1'b1);
  a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (triggered && trc_valid && trc_ready) |=> tcnt == $past(tcnt) - 1'b1);
  a_r8_pad_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(flushing) && $past(live)) |-> wptr[1:0] == 2'd0);
  a_r9_flush_stops: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(flushing) && $past(live && stop_fl)) |-> (stopped && !trc_ready));
  a_r10_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !wr_ctrl) |=> !trc_ready);
endmodule

// File: tb/trace_ring_sink_bench.sv
module trace_ring_sink_bench;
  localparam int CLK_P = 10;
  localparam int AW = 4;
  localparam int DEP = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic trc_valid = 1'b0, trc_ready, trig_in = 1'b0, flush_in = 1'b0;
  logic [31:0] trc_data = '0;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  trace_ring_sink #(.ADDR_W(AW), .RA_W(12)) u_trace_ring_sink (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .trc_valid(trc_valid), .trc_data(trc_data), .trc_ready(trc_ready),
    .trig_in(trig_in), .flush_in(flush_in));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic push(input int cycles, input logic [31:0] base, output int acc);
    acc = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk); trc_valid = 1'b1; trc_data = base + 32'(acc);
      #1; if (trc_ready) acc++;
    end
    @(negedge clk); trc_valid = 1'b0;
  endtask

  task automatic pulse_trig;
    @(negedge clk); trig_in = 1'b1; @(negedge clk); trig_in = 1'b0;
  endtask

  task automatic restart(input logic [31:0] fctrl, input logic [31:0] cnt);
    wr(12'h020, 0); wr(12'h018, 0); wr(12'h01C, cnt); wr(12'h304, fctrl); wr(12'h020, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int acc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", 32'(trc_ready), 0);
    rd(12'h00C, v); chk("R1 status", v, 0);
    rd(12'h300, v); chk("R1 stopped", v, 32'h2);
    rd(12'h018, v); chk("R1 wptr", v, 0);
    rd(12'h014, v); chk("R1 rptr", v, 0);
    rd(12'h004, v); chk("R2 depth", v, DEP);
    chk("R2 bit31", 32'(v[31]), 0);

    for (int i = 0; i < DEP + 3; i++) begin
      wr(12'h024, 32'hA000_0000 + 32'(i) * 32'h0001_0003);
      if (i == DEP - 2) begin rd(12'h00C, v); chk("R4 not yet full", v, 0); end
      if (i == DEP - 1) begin rd(12'h00C, v); chk("R4 full on wrap", v, 1); end
    end
    rd(12'h018, v); chk("R3 wptr wrapped", v, 3);
    for (int i = 0; i < DEP; i++) begin
      int src;
      src = (i < 3) ? i + DEP : i;
      rd(12'h010, v); chk("R3 window read", v, 32'hA000_0000 + 32'(src) * 32'h0001_0003);
    end
    rd(12'h014, v); chk("R3 rptr wrapped", v, 0);
    rd(12'h00C, v); chk("R4 sticky", v, 1);
    wr(12'h018, 32'hFFFF_FFF5);
    rd(12'h018, v); chk("R6 wptr masked", v, 5);
    rd(12'h00C, v); chk("R4 cleared when off", v, 0);
    wr(12'h014, 32'h0000_0039);
    rd(12'h014, v); chk("R6 rptr masked", v, 9);

    restart(0, 0);
    @(negedge clk); chk("R5 ready when on", 32'(trc_ready), 1);
    push(10, 32'h5500_0000, acc); chk("R5 accepted", 32'(acc), 10);
    rd(12'h018, v); chk("R5 wptr", v, 10);
    wr(12'h014, 0);
    for (int i = 0; i < 10; i++) begin
      rd(12'h010, v); chk("R5 stored order", v, 32'h5500_0000 + 32'(i));
    end
    push(DEP, 32'h6600_0000, acc);
    rd(12'h00C, v); chk("R4 full by trace", v, 1);
    wr(12'h018, 0);
    rd(12'h00C, v); chk("R4 kept while capturing", v, 1);

    restart(0, 2);
    pulse_trig;
    push(8, 32'h7700_0000, acc); chk("R7 trigger ignored", 32'(acc), 8);
    wr(12'h020, 0);
    @(negedge clk); chk("R10 ready off", 32'(trc_ready), 0);
    rd(12'h300, v); chk("R10 stopped", v, 32'h2);

    restart(32'h2000, 5);
    push(3, 32'h8800_0000, acc); chk("R7 pre-trigger", 32'(acc), 3);
    pulse_trig;
    push(20, 32'h8800_0100, acc); chk("R7 post count", 32'(acc), 5);
    rd(12'h018, v); chk("R7 wptr", v, 8);
    rd(12'h01C, v); chk("R7 count zero", v, 0);
    rd(12'h300, v); chk("R7 stopped", v, 32'h2);
    wr(12'h020, 1);
    @(negedge clk); chk("R10 rearm", 32'(trc_ready), 1);

    restart(32'h2000, 0);
    pulse_trig;
    push(6, 32'h9900_0000, acc); chk("R7 zero count", 32'(acc), 0);

    restart(32'h1000, 0);
    push(5, 32'hBB00_0000, acc); chk("R9 pre-flush", 32'(acc), 5);
    @(negedge clk); flush_in = 1'b1; @(negedge clk); flush_in = 1'b0;
    rd(12'h304, v); chk("R8 busy bit", v & 32'h40, 32'h40);
    repeat (10) @(negedge clk);
    rd(12'h304, v); chk("R8 busy cleared", v & 32'h40, 0);
    rd(12'h018, v); chk("R8 padded ptr", v, 8);
    rd(12'h300, v); chk("R9 stopped", v, 32'h2);
    chk("R9 not ready", 32'(trc_ready), 0);
    wr(12'h014, 4);
    rd(12'h010, v); chk("R8 last word", v, 32'hBB00_0004);
    for (int i = 5; i < 8; i++) begin
      rd(12'h010, v); chk("R8 zero pad", v, 0);
    end

    restart(0, 0);
    push(2, 32'hCC00_0000, acc);
    wr(12'h304, 32'h40);
    repeat (8) @(negedge clk);
    rd(12'h018, v); chk("R8 reg flush pad", v, 4);
    chk("R9 continues", 32'(trc_ready), 1);

    rd(12'h100, v); chk("R11 unmapped", v, 0);
    rd(12'h020, v); chk("R11 ctrl next cycle", v, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule